// File: doc/BRIEF.md
# Saturating Single-Precision Add/Subtract Unit

This unit adds or subtracts two 32-bit floating-point words in a format that has no infinities, no NaNs and no denormals. A word is a sign bit, an 8-bit biased exponent (bias 127) and a 23-bit fraction with a hidden leading one. Exponent codes 1 to 255 are all ordinary finite numbers. A zero exponent code always reads as a zero of the given sign.

Before the operation the unit trims the operand with the smaller exponent, so that only one guard bit survives alignment. It then truncates the result toward zero. A result too large for the format saturates instead of wrapping. A nonzero result too small for the format flushes its exponent to zero. Overflow and underflow are reported on plain flags that describe the most recent operation and on sticky flags that accumulate. A separate accumulator-overflow flag tracks overflow on operations whose destination is the accumulator.

An operation starts with a one-cycle strobe and answers a fixed two cycles later with a one-cycle done pulse. A new operation may start on every cycle.

Top module: `sat_fadd`

## Requirements
- R1: Exponent code 255 is finite. For example, 0x7F800000 minus 0x7F000000 gives 0x7F000000 with no flag raised.
- R2: An operand whose exponent field is 0 is a zero of its sign bit, whatever its fraction bits hold. For example, 0x00123456 plus 0x40400000 gives 0x40400000.
- R3: When the exponent fields differ by 25 or more, the operand with the smaller exponent is replaced by a zero carrying its own sign before the operation. For example, 0x4C000000 minus 0x3F800000 gives 0x4C000000.
- R4: When the exponent fields differ by d, with 1 ≤ d ≤ 24, the lowest d−1 bits of the smaller-exponent operand's word are cleared before alignment. For example, 0x3F800000 minus 0x33800001 gives 0x3F7FFFFF.
- R5: When the exponent fields are equal, both operands enter the operation unchanged.
- R6: The exact result of the trimmed operands is truncated toward zero and is never rounded up. For example, 0x3F800003 plus 0x3F800000 gives 0x40000001.
- R7: A result whose biased exponent would exceed 255 is output as the result sign followed by 31 one bits. It sets ovfFlag and ovfSticky.
- R8: A nonzero result whose biased exponent would be below 1 is output with its sign and normalized fraction bits, and with the exponent field forced to 0. It sets unfFlag and unfSticky.
- R9: An exactly zero result raises no flag. It is negative only when both effective operands are negative; otherwise it is 0x00000000.
- R10: ovfFlag and unfFlag describe only the most recently completed operation and are cleared when that operation raises neither condition. ovfSticky and unfSticky stay set until reset.
- R11: An operation with dstAcc high loads accOvf with its own overflow outcome, which clears accOvf at the start of that operation. An operation with dstAcc low leaves accOvf unchanged.
- R12: Each start strobe produces exactly one done pulse, two clock edges after the edge that samples start. Result and flags are valid while done is high, and back-to-back starts are accepted.
- R13: With opSub high, the operation is opA plus opB with opB's sign bit inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation on the sampled operands |
| opSub | input | 1 | 1 = subtract opB from opA, 0 = add |
| dstAcc | input | 1 | 1 = result is destined for the accumulator |
| opA | input | 32 | First operand word |
| opB | input | 32 | Second operand word |
| result | output | 32 | Result word, valid while done is high |
| done | output | 1 | One-cycle completion pulse |
| ovfFlag | output | 1 | Overflow on the last completed operation |
| unfFlag | output | 1 | Underflow on the last completed operation |
| ovfSticky | output | 1 | Overflow seen since reset |
| unfSticky | output | 1 | Underflow seen since reset |
| accOvf | output | 1 | Overflow on the last accumulator-destined operation |

## Verification
A wrong trim mask or a wrong alignment shift shows up in the low fraction bits of the very result that done marks. The guard-bit and far-operand cases are therefore chosen so that an ordinary rounding unit would give a different word. A stale flag register shows up on the next operation's done cycle, as a plain flag left set or an accumulator flag changed by a non-accumulator operation. A fault in the strobe chain shows up within three cycles as a missing, doubled or shifted done pulse.

// File: rtl/sat_fadd_pkg.sv
package sat_fadd_pkg;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int WORD_W  = 1 + EXP_W + MAN_W;
  localparam int SIG_W   = MAN_W + 1;
  localparam int GUARD_W = 1;
  localparam int SUM_W   = SIG_W + GUARD_W + 1;
  localparam int LEAD_W  = $clog2(SUM_W);
  localparam int EXPR_W  = EXP_W + 3;
  localparam int EXPD_W  = EXP_W + 2;
  localparam int DROP_LIMIT = SIG_W + GUARD_W;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fword_t;

  typedef struct packed {
    logic loadOps;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/sat_fadd_ctrl.sv
module sat_fadd_ctrl
  import sat_fadd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strobes,
  output logic    done
);
  logic stageValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      done       <= 1'b0;
    end else begin
      stageValid <= start;
      done       <= stageValid;
    end
  end

  always_comb begin
    strobes.loadOps = start;
    strobes.commit  = stageValid;
  end

  // R12: every start answers with done two edges later
  a_r12_latency: assert property (@(posedge clk) disable iff (!rstN)
    start |=> ##1 done);
  // R12: no done without a start two edges earlier
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ##1 !done);
endmodule

// File: rtl/sat_fadd_premask.sv
module sat_fadd_premask
  import sat_fadd_pkg::*;
(
  input  fword_t inA,
  input  fword_t inB,
  output fword_t outA,
  output fword_t outB
);
  logic signed [EXPD_W-1:0] diff;
  logic        [EXPD_W-1:0] clrA;
  logic        [EXPD_W-1:0] clrB;

  always_comb begin
    diff = $signed({2'b00, inA.exp}) - $signed({2'b00, inB.exp});
    clrB = EXPD_W'(diff - 1);
    clrA = EXPD_W'(-diff - 1);
    outA = inA;
    outB = inB;
    if (diff >= DROP_LIMIT) begin
      outB.exp = '0;
      outB.man = '0;
    end else if (diff > 0) begin
      outB.man = inB.man & ({MAN_W{1'b1}} << clrB);
    end else if (diff <= -DROP_LIMIT) begin
      outA.exp = '0;
      outA.man = '0;
    end else if (diff < 0) begin
      outA.man = inA.man & ({MAN_W{1'b1}} << clrA);
    end
  end
endmodule

// File: rtl/sat_fadd_datapath.sv
module sat_fadd_datapath
  import sat_fadd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              opSub,
  input  logic              dstAcc,
  output logic [WORD_W-1:0] result,
  output logic              ovfFlag,
  output logic              unfFlag,
  output logic              ovfSticky,
  output logic              unfSticky,
  output logic              accOvf
);
  fword_t rawA, rawB, trimA, trimB;
  fword_t holdA, holdB;
  logic   holdAcc;

  always_comb begin
    rawA = fword_t'(opA);
    rawB = fword_t'(opB);
    rawB.sign = opB[WORD_W-1] ^ opSub;
  end

  sat_fadd_premask u_premask (
    .inA (rawA),
    .inB (rawB),
    .outA(trimA),
    .outB(trimB)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdA   <= '0;
      holdB   <= '0;
      holdAcc <= 1'b0;
    end else if (strobes.loadOps) begin
      holdA   <= trimA;
      holdB   <= trimB;
      holdAcc <= dstAcc;
    end
  end

  logic [SIG_W-1:0]  sigA, sigB, bigSig, smallSig;
  logic [EXP_W-1:0]  bigE, smallE, shiftAmt;
  logic              bigSign, smallSign, aBig, effSub;
  logic [SIG_W:0]    alignedSmall;
  logic [SUM_W-1:0]  sum;
  logic [LEAD_W-1:0] lead, lzAmt;
  logic              found, carry;
  logic [SIG_W:0]    normWord;
  logic signed [EXPR_W-1:0] expRes;
  logic              overflow, underflow;
  logic [WORD_W-1:0] nextResult;

  always_comb begin
    sigA = (holdA.exp == '0) ? '0 : {1'b1, holdA.man};
    sigB = (holdB.exp == '0) ? '0 : {1'b1, holdB.man};
    aBig = {holdA.exp, sigA} >= {holdB.exp, sigB};
    if (aBig) begin
      bigE = holdA.exp; bigSig = sigA; bigSign = holdA.sign;
      smallE = holdB.exp; smallSig = sigB; smallSign = holdB.sign;
    end else begin
      bigE = holdB.exp; bigSig = sigB; bigSign = holdB.sign;
      smallE = holdA.exp; smallSig = sigA; smallSign = holdA.sign;
    end
    shiftAmt     = bigE - smallE;
    alignedSmall = {smallSig, {GUARD_W{1'b0}}} >> shiftAmt;
    effSub       = bigSign ^ smallSign;
    if (effSub)
      sum = {1'b0, bigSig, {GUARD_W{1'b0}}} - {1'b0, alignedSmall};
    else
      sum = {1'b0, bigSig, {GUARD_W{1'b0}}} + {1'b0, alignedSmall};
  end

  always_comb begin
    lead = '0;
    for (int i = 0; i < SUM_W; i++)
      if (sum[i]) lead = LEAD_W'(i);
    found = |sum;
    carry = sum[SUM_W-1];
    lzAmt = carry ? '0 : LEAD_W'(SUM_W - 2) - lead;
    if (carry) normWord = sum[SUM_W-1:1];
    else       normWord = sum[SUM_W-2:0] << lzAmt;
    expRes = EXPR_W'(bigE) + EXPR_W'(carry) - EXPR_W'(lzAmt);
    overflow  = found && (expRes > $signed(EXPR_W'(EXP_MAX)));
    underflow = found && (expRes < $signed(EXPR_W'(1)));
    if (!found)
      nextResult = {bigSign & ~effSub, {(WORD_W-1){1'b0}}};
    else if (overflow)
      nextResult = {bigSign, {(WORD_W-1){1'b1}}};
    else if (underflow)
      nextResult = {bigSign, {EXP_W{1'b0}}, normWord[SIG_W-1:GUARD_W]};
    else
      nextResult = {bigSign, expRes[EXP_W-1:0], normWord[SIG_W-1:GUARD_W]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      ovfFlag   <= 1'b0;
      unfFlag   <= 1'b0;
      ovfSticky <= 1'b0;
      unfSticky <= 1'b0;
      accOvf    <= 1'b0;
    end else if (strobes.commit) begin
      result    <= nextResult;
      ovfFlag   <= overflow;
      unfFlag   <= underflow;
      ovfSticky <= ovfSticky | overflow;
      unfSticky <= unfSticky | underflow;
      if (holdAcc) accOvf <= overflow;
    end
  end

  // R7: an overflow always leaves a saturated magnitude
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> (result[WORD_W-2:0] == '1));
  // R8: an underflow leaves a zero exponent field
  a_r8_exp_cleared: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |-> (result[WORD_W-2:MAN_W] == '0));
  // R8: overflow and underflow never coexist
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfFlag && unfFlag));
  // R10: plain flags are covered by their sticky copies
  a_r10_sticky_ovf: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> ovfSticky);
  a_r10_sticky_unf: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |-> unfSticky);
  // R10: flags move only when an operation completes
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(ovfFlag) && $stable(unfFlag)));
  // R11: the accumulator flag rises only together with overflow
  a_r11_acc_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accOvf) |-> ovfFlag);
endmodule

// File: rtl/sat_fadd.sv
module sat_fadd
  import sat_fadd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opSub,
  input  logic              dstAcc,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result,
  output logic              done,
  output logic              ovfFlag,
  output logic              unfFlag,
  output logic              ovfSticky,
  output logic              unfSticky,
  output logic              accOvf
);
  strobe_t strobes;

  sat_fadd_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .done   (done)
  );

  sat_fadd_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .opSub    (opSub),
    .dstAcc   (dstAcc),
    .result   (result),
    .ovfFlag  (ovfFlag),
    .unfFlag  (unfFlag),
    .ovfSticky(ovfSticky),
    .unfSticky(unfSticky),
    .accOvf   (accOvf)
  );
endmodule

// File: tb/sim_sat_fadd.sv
module sim_sat_fadd;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opSub = 1'b0;
  logic dstAcc = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic done, ovfFlag, unfFlag, ovfSticky, unfSticky, accOvf;

  int checks = 0;
  int fails = 0;
  bit stkO = 0, stkU = 0, accM = 0;
  logic [31:0] lastRes;
  bit finished = 0;

  sat_fadd u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSub(opSub), .dstAcc(dstAcc),
    .opA(opA), .opB(opB), .result(result), .done(done),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag), .ovfSticky(ovfSticky),
    .unfSticky(unfSticky), .accOvf(accOvf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic real pow2(int n);
    real v = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) v = v * 2.0;
    else        for (int i = 0; i < -n; i++) v = v / 2.0;
    return v;
  endfunction

  function automatic real toReal(logic [31:0] w);
    real v;
    if (w[30:23] == 8'd0) return 0.0;
    v = (1.0 + real'(w[22:0]) / 8388608.0) * pow2(int'(w[30:23]) - 127);
    return w[31] ? -v : v;
  endfunction

  // returns {ovf, unf, word}; trimming and truncation per R3, R4, R6
  function automatic logic [33:0] refOp(logic [31:0] a, logic [31:0] b, bit sub);
    int ea, eb, d, ex;
    real s, x;
    logic [31:0] ta, tb, res;
    bit neg, ovf, unf;
    ta = a;
    tb = {b[31] ^ sub, b[30:0]};
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    d = ea - eb;
    if (d >= 25)       tb = {tb[31], 31'd0};
    else if (d > 0)    tb = tb & (32'hFFFF_FFFF << (d - 1));
    else if (d <= -25) ta = {ta[31], 31'd0};
    else if (d < 0)    ta = ta & (32'hFFFF_FFFF << (-d - 1));
    s = toReal(ta) + toReal(tb);
    ovf = 0; unf = 0;
    if (s == 0.0) begin
      res = {(ta[31] && tb[31]), 31'd0};
    end else begin
      neg = (s < 0.0);
      x = neg ? -s : s;
      ex = 127;
      while (x >= 2.0) begin x = x / 2.0; ex++; end
      while (x < 1.0)  begin x = x * 2.0; ex--; end
      res[22:0] = 23'($rtoi((x - 1.0) * 8388608.0));
      res[31] = neg;
      if (ex > 255) begin
        ovf = 1; res = {neg, 31'h7FFF_FFFF};
      end else if (ex < 1) begin
        unf = 1; res[30:23] = 8'd0;
      end else res[30:23] = 8'(ex);
    end
    return {ovf, unf, res};
  endfunction

  // one operation, result checked against the model; R12 timing checked each time
  task automatic runOp(string req, logic [31:0] a, logic [31:0] b, bit sub, bit acc);
    logic [33:0] exp;
    exp = refOp(a, b, sub);
    @(negedge clk);
    opA = a; opB = b; opSub = sub; dstAcc = acc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R12 done early", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R12 done pulse", {31'd0, done}, 32'd1);
    check({req, " result"}, result, exp[31:0]);
    check("R7 ovfFlag", {31'd0, ovfFlag}, {31'd0, exp[33]});
    check("R8 unfFlag", {31'd0, unfFlag}, {31'd0, exp[32]});
    stkO |= exp[33]; stkU |= exp[32];
    if (acc) accM = exp[33];
    check("R10 sticky", {30'd0, ovfSticky, unfSticky}, {30'd0, stkO, stkU});
    check("R11 accOvf", {31'd0, accOvf}, {31'd0, accM});
    lastRes = result;
  endtask

  task automatic testReset();
    check("R12 reset", {26'd0, done, ovfFlag, unfFlag, ovfSticky, unfSticky, accOvf}, 32'd0);
    check("R12 reset result", result, 32'd0);
  endtask

  task automatic testExp255();
    runOp("R1", 32'h7F80_0000, 32'h7F00_0000, 1, 0);
    check("R1 finite top exponent", lastRes, 32'h7F00_0000);
  endtask

  task automatic testZeroCode();
    runOp("R2", 32'h0012_3456, 32'h4040_0000, 0, 0);
    check("R2 zero code", lastRes, 32'h4040_0000);
  endtask

  task automatic testFar();
    runOp("R3", 32'h4C00_0000, 32'h3F80_0000, 1, 0);
    check("R3 far operand dropped", lastRes, 32'h4C00_0000);
    runOp("R3", 32'h3F80_0000, 32'h4C00_0000, 1, 0);
    check("R3 far operand dropped swap", lastRes, 32'hCC00_0000);
  endtask

  task automatic testGuard();
    runOp("R4", 32'h3F80_0000, 32'h3380_0001, 1, 0);
    check("R4 guard trim", lastRes, 32'h3F7F_FFFF);
  endtask

  task automatic testEqual();
    runOp("R5", 32'h3FC0_0001, 32'h3F80_0001, 1, 0);
    check("R5 equal exponents", lastRes, 32'h3F00_0000);
  endtask

  task automatic testTruncate();
    runOp("R6", 32'h3F80_0003, 32'h3F80_0000, 0, 0);
    check("R6 truncation", lastRes, 32'h4000_0001);
  endtask

  task automatic testOverflow();
    runOp("R7", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0);
    check("R7 positive saturation", lastRes, 32'h7FFF_FFFF);
    runOp("R7", 32'hFF80_0000, 32'hFF80_0000, 0, 0);
    check("R7 negative saturation", lastRes, 32'hFFFF_FFFF);
  endtask

  task automatic testUnderflow();
    runOp("R8", 32'h0080_0003, 32'h0080_0000, 1, 0);
    check("R8 flushed exponent", lastRes, 32'h0040_0000);
  endtask

  task automatic testZero();
    runOp("R9", 32'h4049_0FDB, 32'h4049_0FDB, 1, 0);
    check("R9 cancel zero", lastRes, 32'h0000_0000);
    runOp("R9", 32'h8000_0000, 32'h8000_0000, 0, 0);
    check("R9 negative zero", lastRes, 32'h8000_0000);
  endtask

  task automatic testFlags();
    runOp("R10", 32'h7F80_0000, 32'h7F80_0000, 0, 0);
    runOp("R10", 32'h3F80_0000, 32'h3F80_0000, 0, 0);
    check("R10 plain cleared", {30'd0, ovfFlag, unfFlag}, 32'd0);
  endtask

  task automatic testAcc();
    runOp("R11", 32'h7F80_0000, 32'h7F80_0000, 0, 1);
    check("R11 acc set", {31'd0, accOvf}, 32'd1);
    runOp("R11", 32'h3F80_0000, 32'h3F80_0000, 0, 0);
    check("R11 non-acc keeps", {31'd0, accOvf}, 32'd1);
    runOp("R11", 32'h3F80_0000, 32'h3F80_0000, 0, 1);
    check("R11 acc cleared", {31'd0, accOvf}, 32'd0);
    runOp("R11", 32'h7F80_0000, 32'h7F80_0000, 0, 0);
    check("R11 non-acc overflow ignored", {31'd0, accOvf}, 32'd0);
  endtask

  task automatic testSub();
    runOp("R13", 32'h4000_0000, 32'hC000_0000, 1, 0);
    check("R13 subtract flips sign", lastRes, 32'h4080_0000);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    opA = 32'h3F80_0000; opB = 32'h3F80_0000; opSub = 0; dstAcc = 0; start = 1;
    @(negedge clk);
    opA = 32'h4000_0000; opB = 32'h3F80_0000; opSub = 1;
    @(negedge clk);
    start = 0;
    check("R12 first done", {31'd0, done}, 32'd1);
    check("R12 first result", result, 32'h4000_0000);
    @(negedge clk);
    check("R12 second done", {31'd0, done}, 32'd1);
    check("R12 second result", result, 32'h3F80_0000);
    @(negedge clk);
    check("R12 single pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic testSweep();
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a, b;
      int ea, eb;
      ea = (n % 5 == 0) ? 230 + int'($urandom_range(0, 25)) :
           (n % 5 == 1) ? 1 + int'($urandom_range(0, 25)) : 100 + int'($urandom_range(0, 60));
      eb = ea + int'($urandom_range(0, 60)) - 30;
      if (eb < 0) eb = 0;
      if (eb > 255) eb = 255;
      a = {1'($urandom), 8'(ea), 23'($urandom)};
      b = {1'($urandom), 8'(eb), 23'($urandom)};
      runOp("R4 R6 sweep", a, b, 1'($urandom), 1'($urandom));
    end
  endtask

  task automatic finish();
    if (finished) return;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testExp255();
    testZeroCode();
    testFar();
    testGuard();
    testEqual();
    testTruncate();
    testOverflow();
    testUnderflow();
    testZero();
    testFlags();
    testAcc();
    testSub();
    testBackToBack();
    testSweep();
    finish();
  end
endmodule